// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block decides which memory device answers each access of an 8-bit CPU with a 64 KB address space. The space is divided into four 16 KB sections, selected by address bits 15..14. The devices are a boot EPROM, a system ROM, video RAM and four 16 KB user-RAM banks. Three things decide where a section points:

- a 5-bit configuration register that software loads with an I/O write to port 0x3E;
- a layout switch that picks the native layout or the CP/M-style layout;
- a bank switch that, in the native layout, picks which pair of user-RAM banks fills the upper 32 KB.

In the CP/M-style layout, the lowest section can hold firmware, ROM or user RAM 0. A further flag marks the alternate variant of user RAM 0.

The block also gives an enable for the native video controller's I/O decode. That enable is held low for any port whose address bits 7 and 6 are both zero, so the controller stays off the configuration port.

All outputs come from registers, so each output shows the access presented in the previous cycle. Reset is synchronous and active high. The two switches pass through a short synchronizer before the decode uses them.

Top module: `bankmap_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go low after that edge and the configuration clears to 0b00000. After reset, a native-layout access to section 0 selects the EPROM.
- R2: The configuration loads `wdata[4:0]` as {S4,S3,S2,S1,S0} (S0 = bit 0) only on an edge where `io_req`, `wr_en` and `a_low == 0x3E` are all high. It is unchanged by writes to other ports, by I/O reads of port 0x3E, and by memory writes whose low address is 0x3E.
- R3: Native layout (`mode_cpm` = 0), section 0 (`a_top` = 0): EPROM when S0 = 0, ROM when S0 = 1. S1 and S3 have no effect.
- R4: Native layout, section 1: always video RAM.
- R5: Native layout: section 2 selects user RAM 2 when S4 = 1 and `bank_hi` = 1, otherwise user RAM 0. Section 3 selects user RAM 3 under the same condition, otherwise user RAM 1.
- R6: CP/M layout (`mode_cpm` = 1): section 2 is always user RAM 2 and section 3 is always user RAM 3, whatever S4 and `bank_hi` are.
- R7: CP/M layout, section 1: video RAM when S2 = 0, user RAM 1 when S2 = 1.
- R8: CP/M layout, section 0, checked in this order:
  - S0 = 0 selects the EPROM;
  - S0 = 1 with S1 = 0 selects the ROM;
  - S0 = S1 = 1 selects user RAM 0, with `uram0_alt` equal to S3.
  
  `uram0_alt` is never high unless `cs_uram[0]` is high.
- R9: One cycle after a cycle with `mem_req` high, exactly one of `cs_eprom`, `cs_rom`, `cs_vram`, `cs_uram[3:0]` is high. One cycle after a cycle with `mem_req` low, all of them and `uram0_alt` are low.
- R10: Chip selects reflect the inputs of the previous cycle. When a configuration write and a memory access fall in the same cycle, the access is decoded with the old configuration, and the new value applies from the next access.
- R11: `vid_io_en` is high one cycle after a cycle with `io_req` high and `a_low[7:6]` not both zero, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Memory access in progress |
| io_req | input | 1 | I/O access in progress |
| wr_en | input | 1 | Write strobe |
| a_top | input | 2 | Address bits 15..14 (section index) |
| a_low | input | 8 | Address bits 7..0 (I/O port) |
| wdata | input | 5 | Data bits 4..0 |
| mode_cpm | input | 1 | Layout switch, 1 = CP/M layout |
| bank_hi | input | 1 | Bank switch, 1 = upper user-RAM pair |
| cs_eprom | output | 1 | EPROM select |
| cs_rom | output | 1 | ROM select |
| cs_vram | output | 1 | Video RAM select |
| cs_uram | output | 4 | User-RAM bank selects, bit n = bank n |
| uram0_alt | output | 1 | Alternate variant of user RAM 0 |
| vid_io_en | output | 1 | Video controller I/O enable |

## Verification
A configuration write and a memory decode can fall in the same cycle: an edge where `mem_req`, `io_req` and `wr_en` are all high with `a_low` equal to 0x3E. The bench forces this with the configuration at zero and the write data at 0b00001, both in section 0 in the native layout. It expects the EPROM select on that access and the ROM select on the access that follows. This shows that the registered decode reads the configuration from before the write.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int CFG_W   = 5;
  localparam int SEC_W   = 2;
  localparam int NUM_SEC = 1 << SEC_W;

  typedef enum logic [2:0] {
    DEV_EPROM = 3'd0,
    DEV_ROM   = 3'd1,
    DEV_VRAM  = 3'd2,
    DEV_URAM0 = 3'd3,
    DEV_URAM1 = 3'd4,
    DEV_URAM2 = 3'd5,
    DEV_URAM3 = 3'd6
  } dev_e;

  localparam int NUM_DEV = 7;

  typedef struct packed {
    logic s4;
    logic s3;
    logic s2;
    logic s1;
    logic s0;
  } cfg_t;

  typedef struct packed {
    dev_e dev;
    logic alt;
  } route_t;
endpackage

// File: rtl/cfg_port_reg.sv
module cfg_port_reg
  import bankmap_pkg::*;
#(
  parameter int               PORT_W    = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] port,
  input  logic [CFG_W-1:0]  wdata,
  output cfg_t              cfg_q
);
  logic hit;

  assign hit = io_req && wr_en && (port == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (hit)
      cfg_q <= cfg_t'(wdata);
  end
endmodule

// File: rtl/switch_sync.sv
module switch_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sw_in,
  output logic [WIDTH-1:0] sw_q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= sw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign sw_q = pipe[STAGES-1];
endmodule

// File: rtl/route_decode.sv
module route_decode
  import bankmap_pkg::*;
(
  input  logic [SEC_W-1:0] sec,
  input  cfg_t             cfg,
  input  logic             mode_cpm,
  input  logic             bank_hi,
  output route_t           route
);
  logic upper_pair;

  assign upper_pair = mode_cpm || (cfg.s4 && bank_hi);

  always_comb begin
    route.dev = DEV_EPROM;
    route.alt = 1'b0;
    unique case (sec)
      2'd0: begin
        if (!cfg.s0)
          route.dev = DEV_EPROM;
        else if (!mode_cpm || !cfg.s1)
          route.dev = DEV_ROM;
        else begin
          route.dev = DEV_URAM0;
          route.alt = cfg.s3;
        end
      end
      2'd1: route.dev = (mode_cpm && cfg.s2) ? DEV_URAM1 : DEV_VRAM;
      2'd2: route.dev = upper_pair ? DEV_URAM2 : DEV_URAM0;
      default: route.dev = upper_pair ? DEV_URAM3 : DEV_URAM1;
    endcase
  end
endmodule

// File: rtl/cs_register.sv
module cs_register
  import bankmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mem_req,
  input  route_t             sel,
  input  logic               vid_hit,
  output logic [NUM_DEV-1:0] cs_q,
  output logic               alt_q,
  output logic               vid_q
);
  logic [NUM_DEV-1:0] cs_d;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
    assign cs_d[d] = mem_req && (sel.dev == dev_e'(3'(d)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= '0;
      alt_q <= 1'b0;
      vid_q <= 1'b0;
    end else begin
      cs_q  <= cs_d;
      alt_q <= mem_req && sel.alt;
      vid_q <= vid_hit;
    end
  end
endmodule

// File: rtl/bankmap_decoder.sv
module bankmap_decoder
  import bankmap_pkg::*;
#(
  parameter int                PORT_W      = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR   = 8'h3E,
  parameter logic [PORT_W-1:0] VID_MASK    = 8'hC0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              wr_en,
  input  logic [SEC_W-1:0]  a_top,
  input  logic [PORT_W-1:0] a_low,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              mode_cpm,
  input  logic              bank_hi,
  output logic              cs_eprom,
  output logic              cs_rom,
  output logic              cs_vram,
  output logic [3:0]        cs_uram,
  output logic              uram0_alt,
  output logic              vid_io_en
);
  cfg_t               cfg_q;
  logic [1:0]         sw_q;
  logic               mode_q;
  logic               bank_q;
  route_t             sec_route [NUM_SEC];
  route_t             sel;
  logic               vid_hit;
  logic [NUM_DEV-1:0] cs_q;

  cfg_port_reg #(.PORT_W(PORT_W), .PORT_ADDR(PORT_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .io_req(io_req), .wr_en(wr_en),
    .port(a_low), .wdata(wdata), .cfg_q(cfg_q)
  );

  switch_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sw (
    .clk(clk), .rst(rst), .sw_in({bank_hi, mode_cpm}), .sw_q(sw_q)
  );

  assign mode_q = sw_q[0];
  assign bank_q = sw_q[1];

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    route_decode u_rd (
      .sec(SEC_W'(s)), .cfg(cfg_q), .mode_cpm(mode_q),
      .bank_hi(bank_q), .route(sec_route[s])
    );
  end

  assign sel     = sec_route[a_top];
  assign vid_hit = io_req && ((a_low & VID_MASK) != '0);

  cs_register u_cs (
    .clk(clk), .rst(rst), .mem_req(mem_req), .sel(sel), .vid_hit(vid_hit),
    .cs_q(cs_q), .alt_q(uram0_alt), .vid_q(vid_io_en)
  );

  assign cs_eprom = cs_q[DEV_EPROM];
  assign cs_rom   = cs_q[DEV_ROM];
  assign cs_vram  = cs_q[DEV_VRAM];
  assign cs_uram  = cs_q[DEV_URAM3:DEV_URAM0];
endmodule

// File: rtl/bankmap_decoder_chk.sv
module bankmap_decoder_chk
  import bankmap_pkg::*;
#(
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h3E
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              io_req,
  input logic              wr_en,
  input logic [SEC_W-1:0]  a_top,
  input logic [PORT_W-1:0] a_low,
  input logic              mode_q,
  input cfg_t              cfg_q,
  input logic              cs_eprom,
  input logic              cs_rom,
  input logic              cs_vram,
  input logic [3:0]        cs_uram,
  input logic              uram0_alt,
  input logic              vid_io_en
);
  logic [6:0] cs_all;
  assign cs_all = {cs_uram, cs_vram, cs_rom, cs_eprom};

  // R9
  one_cs_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> ($countones(cs_all) == 1));

  // R9
  idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> (cs_all == '0 && !uram0_alt));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_req && wr_en && a_low == PORT_ADDR) |=> $stable(cfg_q));

  // R4
  native_vram_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mode_q && a_top == 2'd1) |=> cs_vram);

  // R6
  cpm_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mode_q && a_top[1]) |=> (cs_uram[3] || cs_uram[2]));

  // R8
  alt_uram0_chk: assert property (@(posedge clk) disable iff (rst)
    uram0_alt |-> cs_uram[0]);

  // R11
  vid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (io_req && a_low[7:6] == 2'b00) |=> !vid_io_en);
endmodule

bind bankmap_decoder bankmap_decoder_chk #(.PORT_W(PORT_W), .PORT_ADDR(PORT_ADDR)) chk_i (
  .clk(clk), .rst(rst), .mem_req(mem_req), .io_req(io_req), .wr_en(wr_en),
  .a_top(a_top), .a_low(a_low), .mode_q(mode_q), .cfg_q(cfg_q),
  .cs_eprom(cs_eprom), .cs_rom(cs_rom), .cs_vram(cs_vram), .cs_uram(cs_uram),
  .uram0_alt(uram0_alt), .vid_io_en(vid_io_en)
);

// File: tb/bankmap_decoder_test.sv
module bankmap_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mem_req = 1'b0, io_req = 1'b0, wr_en = 1'b0;
  logic [1:0] a_top = '0;
  logic [7:0] a_low = '0;
  logic [4:0] wdata = '0;
  logic       mode_cpm = 1'b0, bank_hi = 1'b0;
  logic       cs_eprom, cs_rom, cs_vram, uram0_alt, vid_io_en;
  logic [3:0] cs_uram;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected select codes: {uram3,uram2,uram1,uram0,vram,rom,eprom}
  localparam logic [6:0] E_EP = 7'h01, E_RO = 7'h02, E_VR = 7'h04,
                         E_U0 = 7'h08, E_U1 = 7'h10, E_U2 = 7'h20, E_U3 = 7'h40;

  // {mode, bank, cfg[4:0], section[1:0], cs[6:0], alt}
  localparam int NV = 26;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b0,5'b00000,2'd0,E_EP,1'b0},
    {1'b0,1'b0,5'b00001,2'd0,E_RO,1'b0},
    {1'b0,1'b1,5'b11110,2'd0,E_EP,1'b0},
    {1'b0,1'b0,5'b01111,2'd0,E_RO,1'b0},
    {1'b0,1'b0,5'b00000,2'd1,E_VR,1'b0},
    {1'b0,1'b1,5'b11111,2'd1,E_VR,1'b0},
    {1'b0,1'b0,5'b10000,2'd2,E_U0,1'b0},
    {1'b0,1'b1,5'b10000,2'd2,E_U2,1'b0},
    {1'b0,1'b1,5'b01111,2'd2,E_U0,1'b0},
    {1'b0,1'b0,5'b10000,2'd3,E_U1,1'b0},
    {1'b0,1'b1,5'b10000,2'd3,E_U3,1'b0},
    {1'b0,1'b1,5'b01111,2'd3,E_U1,1'b0},
    {1'b1,1'b0,5'b00000,2'd2,E_U2,1'b0},
    {1'b1,1'b1,5'b00000,2'd3,E_U3,1'b0},
    {1'b1,1'b0,5'b11111,2'd3,E_U3,1'b0},
    {1'b1,1'b0,5'b00000,2'd1,E_VR,1'b0},
    {1'b1,1'b0,5'b00100,2'd1,E_U1,1'b0},
    {1'b1,1'b1,5'b11011,2'd1,E_VR,1'b0},
    {1'b1,1'b0,5'b00000,2'd0,E_EP,1'b0},
    {1'b1,1'b0,5'b11110,2'd0,E_EP,1'b0},
    {1'b1,1'b0,5'b00001,2'd0,E_RO,1'b0},
    {1'b1,1'b0,5'b01101,2'd0,E_RO,1'b0},
    {1'b1,1'b0,5'b00011,2'd0,E_U0,1'b0},
    {1'b1,1'b0,5'b01011,2'd0,E_U0,1'b1},
    {1'b1,1'b1,5'b11111,2'd0,E_U0,1'b1},
    {1'b1,1'b0,5'b10111,2'd0,E_U0,1'b0}
  };

  bankmap_decoder uut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .io_req(io_req), .wr_en(wr_en),
    .a_top(a_top), .a_low(a_low), .wdata(wdata), .mode_cpm(mode_cpm),
    .bank_hi(bank_hi), .cs_eprom(cs_eprom), .cs_rom(cs_rom), .cs_vram(cs_vram),
    .cs_uram(cs_uram), .uram0_alt(uram0_alt), .vid_io_en(vid_io_en)
  );

  always #5 clk = ~clk;

  function automatic logic [6:0] cs_now();
    return {cs_uram, cs_vram, cs_rom, cs_eprom};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic set_sw(input logic m, input logic b);
    @(negedge clk);
    mode_cpm = m;
    bank_hi  = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic io_op(input logic wr, input logic [7:0] port, input logic [4:0] d);
    @(negedge clk);
    io_req = 1'b1; wr_en = wr; a_low = port; wdata = d;
    @(negedge clk);
    io_req = 1'b0; wr_en = 1'b0;
  endtask

  task automatic mem_read(input logic [1:0] sec, output logic [6:0] cs,
                          output logic alt);
    @(negedge clk);
    mem_req = 1'b1; a_top = sec; a_low = 8'h5A;
    @(negedge clk);
    cs = cs_now(); alt = uram0_alt;
    mem_req = 1'b0;
  endtask

  function automatic string vec_tag(input logic m, input logic [1:0] s);
    if (!m) return (s == 2'd0) ? "R3" : (s == 2'd1) ? "R4" : "R5";
    return (s == 2'd0) ? "R8" : (s == 2'd1) ? "R7" : "R6";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] cs;
    logic       alt;

    // R1: outputs held low under reset even with a request present
    @(negedge clk);
    mem_req = 1'b1; io_req = 1'b1; a_low = 8'hFE;
    repeat (2) @(negedge clk);
    check({cs_now(), uram0_alt, vid_io_en} == '0, "R1 reset outputs",
          {cs_now(), uram0_alt}, 8'h00);
    mem_req = 1'b0; io_req = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    mem_read(2'd0, cs, alt);
    check(cs == E_EP, "R1 boot EPROM", {1'b0, cs}, {1'b0, E_EP});

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic       vm, vb, va;
      logic [4:0] vc;
      logic [1:0] vs;
      logic [6:0] ve;
      {vm, vb, vc, vs, ve, va} = VEC[i];
      set_sw(vm, vb);
      io_op(1'b1, 8'h3E, vc);
      mem_read(vs, cs, alt);
      check(cs == ve && alt == va, vec_tag(vm, vs), {cs, alt}, {ve, va});
      check($countones(cs) == 1, "R9 one select", {1'b0, cs}, 8'h01);
    end

    // R9: idle gives no selects
    set_sw(1'b1, 1'b0);
    io_op(1'b1, 8'h3E, 5'b01011);
    @(negedge clk);
    @(negedge clk);
    check(cs_now() == '0 && !uram0_alt, "R9 idle", {cs_now(), uram0_alt}, 8'h00);

    // R2: ignored writes
    set_sw(1'b0, 1'b0);
    io_op(1'b1, 8'h3E, 5'b00001);
    io_op(1'b1, 8'h3F, 5'b00000);
    mem_read(2'd0, cs, alt);
    check(cs == E_RO, "R2 other port ignored", {1'b0, cs}, {1'b0, E_RO});
    io_op(1'b0, 8'h3E, 5'b00000);
    mem_read(2'd0, cs, alt);
    check(cs == E_RO, "R2 io read ignored", {1'b0, cs}, {1'b0, E_RO});
    @(negedge clk);
    mem_req = 1'b1; wr_en = 1'b1; a_top = 2'd0; a_low = 8'h3E; wdata = 5'b00000;
    @(negedge clk);
    mem_req = 1'b0; wr_en = 1'b0;
    mem_read(2'd0, cs, alt);
    check(cs == E_RO, "R2 memory write ignored", {1'b0, cs}, {1'b0, E_RO});

    // R10: configuration write and memory access in the same cycle
    io_op(1'b1, 8'h3E, 5'b00000);
    @(negedge clk);
    mem_req = 1'b1; io_req = 1'b1; wr_en = 1'b1; a_top = 2'd0; a_low = 8'h3E;
    wdata = 5'b00001;
    @(negedge clk);
    cs = cs_now();
    mem_req = 1'b0; io_req = 1'b0; wr_en = 1'b0;
    check(cs == E_EP, "R10 same-cycle uses old config", {1'b0, cs}, {1'b0, E_EP});
    mem_read(2'd0, cs, alt);
    check(cs == E_RO, "R10 new config next access", {1'b0, cs}, {1'b0, E_RO});

    // R11: video controller I/O enable
    @(negedge clk);
    io_req = 1'b1; a_low = 8'hFE;
    @(negedge clk);
    check(vid_io_en == 1'b1, "R11 port 0xFE", {7'd0, vid_io_en}, 8'h01);
    a_low = 8'h3E;
    @(negedge clk);
    check(vid_io_en == 1'b0, "R11 port 0x3E", {7'd0, vid_io_en}, 8'h00);
    a_low = 8'h40;
    @(negedge clk);
    check(vid_io_en == 1'b1, "R11 port 0x40", {7'd0, vid_io_en}, 8'h01);
    io_req = 1'b0;
    @(negedge clk);
    check(vid_io_en == 1'b0, "R11 no request", {7'd0, vid_io_en}, 8'h00);

    // R1: reset in mid-run clears configuration
    set_sw(1'b1, 1'b0);
    io_op(1'b1, 8'h3E, 5'b00011);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_sw(1'b0, 1'b0);
    mem_read(2'd0, cs, alt);
    check(cs == E_EP && !alt, "R1 reset clears config", {cs, alt}, {E_EP, 1'b0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule